// File: doc/BRIEF.md
# Mixed-chain SPI frame sequencer

This block is a serial master for one shared three-wire bus that serves two kinds of receiver at once. One receiver counts bits: it takes the first word clocked after select falls and ignores every later bit. The others form a daisy chain of `CHAIN_LEN` shift-register receivers. These do not count bits; each one decodes the last word it holds when select rises. The sequencer accepts one word for the counting receiver, one word per chain member and a count of filler bits. It then sends a single frame that satisfies both kinds of receiver.

A frame opens with the counting receiver's word. Next come the requested filler bits, always zero, which the chain pushes out and discards. The frame closes with the chain words. The word for the chain member farthest from the master is sent first and the word for the nearest member is sent last. Every word is sent most significant bit first. Select rises as soon as the clock returns high after the final bit. The next frame cannot open until select has stayed high for a fixed gap.

The serial clock idles high. Data changes only when the clock rises, so it is stable at each falling edge, where the receivers sample. One serial half period lasts `DIV` system clocks.

Top module: `chain_frame_tx`

## Requirements
- R1: After reset, sel_n and sclk are 1, and mosi, busy and done are 0.
- R2: The first WORD_W falling sclk edges after sel_n falls carry lead_word, most significant bit first.
- R3: The next fill_bits falling edges (0 to 2^FILL_W-1 of them) carry 0.
- R4: The last WORD_W*CHAIN_LEN falling edges carry the chain words. chain_words[k*WORD_W +: WORD_W] belongs to chain member k, where k=0 is nearest the master. The words go out in order k=CHAIN_LEN-1 down to k=0, each most significant bit first.
- R5: A frame has exactly WORD_W*(CHAIN_LEN+1)+fill_bits falling edges. sel_n rises on the same system clock edge on which sclk returns high after the last bit.
- R6: While sel_n is low, mosi does not change on the clock edge at which sclk falls.
- R7: sclk is 1 whenever sel_n is 1.
- R8: Between two frames, sel_n stays high for at least 4*DIV system clock cycles.
- R9: done is a one-cycle pulse, raised in the cycle after sel_n rises.
- R10: A start request made while busy is 1 is ignored. The frame in flight keeps its latched data and no extra frame follows.
- R11: A start request made while busy is 0 sets busy and pulls sel_n low on the next clock edge. busy stays 1 while sel_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame request, taken only while idle |
| lead_word | input | WORD_W | Word for the bit-counting receiver |
| chain_words | input | WORD_W*CHAIN_LEN | Chain words, slice k for chain member k (k=0 nearest) |
| fill_bits | input | FILL_W | Number of zero filler bits between the two groups |
| busy | output | 1 | Frame or inter-frame gap in progress |
| done | output | 1 | One-cycle pulse after select returns high |
| sel_n | output | 1 | Active-low select |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data |

## Verification
Two events can land on the same clock edge: a new start request, and the close of the previous frame's inter-frame gap. The bench waits for busy to fall and then requests the next frame at once, so each request arrives on the earliest edge the block can accept. The scoreboard checks that the gap was held in full and that the new frame carries only the new data. A second case issues a request with different data in the middle of a frame. The scoreboard checks that the running frame is unchanged bit for bit and that no unexpected frame opens afterwards.

// File: rtl/cf_pkg.sv
package cf_pkg;
    typedef enum logic [1:0] {
        CF_IDLE  = 2'd0,
        CF_SHIFT = 2'd1,
        CF_GAP   = 2'd2
    } cf_state_e;
endpackage

// File: rtl/cf_half_timer.sv
// Counts DIV system clocks per serial half period while run is high.
module cf_half_timer #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/cf_bit_pick.sv
// Maps a frame bit position to the bit value: lead word, zero filler, then
// chain words with the farthest member first, all MSB first.
module cf_bit_pick #(
    parameter int W  = 16,
    parameter int N  = 2,
    parameter int FW = 4,
    parameter int IW = 6
) (
    input  logic [W-1:0]   lead,
    input  logic [W*N-1:0] chain,
    input  logic [FW-1:0]  fill,
    input  logic [IW-1:0]  idx,
    output logic           bit_o
);
    int pos_i;
    int fill_i;
    int rel_i;
    int word_i;
    int lsb_i;
    logic [W-1:0]   lead_sh;
    logic [W*N-1:0] chain_sh;

    always_comb begin
        pos_i    = 32'(idx);
        fill_i   = 32'(fill);
        rel_i    = 0;
        word_i   = 0;
        lsb_i    = 0;
        lead_sh  = '0;
        chain_sh = '0;
        bit_o    = 1'b0;
        if (pos_i < W) begin
            lead_sh = lead >> (W - 1 - pos_i);
            bit_o   = lead_sh[0];
        end else if (pos_i < W + fill_i) begin
            bit_o = 1'b0;
        end else begin
            rel_i    = pos_i - W - fill_i;
            word_i   = N - 1 - (rel_i / W);
            lsb_i    = W - 1 - (rel_i % W);
            chain_sh = chain >> (word_i * W + lsb_i);
            bit_o    = chain_sh[0];
        end
    end
endmodule

// File: rtl/chain_frame_tx.sv
module chain_frame_tx
    import cf_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int CHAIN_LEN = 2,
    parameter int FILL_W    = 4,
    parameter int DIV       = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [WORD_W-1:0]             lead_word,
    input  logic [WORD_W*CHAIN_LEN-1:0]   chain_words,
    input  logic [FILL_W-1:0]             fill_bits,
    output logic                          busy,
    output logic                          done,
    output logic                          sel_n,
    output logic                          sclk,
    output logic                          mosi
);
    localparam int BASE_BITS = WORD_W * (CHAIN_LEN + 1);
    localparam int MAX_BITS  = BASE_BITS + (1 << FILL_W) - 1;
    localparam int IDX_W     = $clog2(MAX_BITS);
    localparam int GAP_CYC   = 4 * DIV;
    localparam int GAP_W     = $clog2(GAP_CYC);

    typedef struct packed {
        cf_state_e                       st;
        logic                            sel_n;
        logic                            sclk;
        logic                            done;
        logic [IDX_W-1:0]                idx;
        logic [GAP_W-1:0]                gap;
        logic [WORD_W-1:0]               lead;
        logic [WORD_W*CHAIN_LEN-1:0]     chain;
        logic [FILL_W-1:0]               fill;
    } regs_t;

    regs_t            r_d, r_q;
    logic             half_tick;
    logic             pick_bit;
    logic [IDX_W-1:0] last_idx;

    assign last_idx = IDX_W'(BASE_BITS) + IDX_W'(r_q.fill) - IDX_W'(1);

    cf_half_timer #(.DIV(DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.st == CF_SHIFT),
        .tick  (half_tick)
    );

    cf_bit_pick #(.W(WORD_W), .N(CHAIN_LEN), .FW(FILL_W), .IW(IDX_W)) u_pick (
        .lead  (r_q.lead),
        .chain (r_q.chain),
        .fill  (r_q.fill),
        .idx   (r_q.idx),
        .bit_o (pick_bit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            CF_IDLE: begin
                if (start) begin
                    r_d.st    = CF_SHIFT;
                    r_d.sel_n = 1'b0;
                    r_d.sclk  = 1'b1;
                    r_d.idx   = '0;
                    r_d.lead  = lead_word;
                    r_d.chain = chain_words;
                    r_d.fill  = fill_bits;
                end
            end
            CF_SHIFT: begin
                if (half_tick) begin
                    if (r_q.sclk) begin
                        r_d.sclk = 1'b0;
                    end else begin
                        r_d.sclk = 1'b1;
                        if (r_q.idx == last_idx) begin
                            r_d.st    = CF_GAP;
                            r_d.sel_n = 1'b1;
                            r_d.gap   = '0;
                        end else begin
                            r_d.idx = r_q.idx + IDX_W'(1);
                        end
                    end
                end
            end
            CF_GAP: begin
                r_d.done = (r_q.gap == '0);
                if (r_q.gap == GAP_W'(GAP_CYC - 1)) begin
                    r_d.st = CF_IDLE;
                end else begin
                    r_d.gap = r_q.gap + GAP_W'(1);
                end
            end
            default: begin
                r_d.st = CF_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.sel_n <= 1'b1;
            r_q.sclk  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy  = (r_q.st != CF_IDLE);
    assign done  = r_q.done;
    assign sel_n = r_q.sel_n;
    assign sclk  = r_q.sclk;
    assign mosi  = (r_q.st == CF_SHIFT) ? pick_bit : 1'b0;
endmodule

// File: rtl/cf_checks.sv
module cf_checks #(
    parameter int DIV = 2
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic sel_n,
    input logic sclk,
    input logic mosi
);
    localparam int GAP_CYC = 4 * DIV;
    localparam int HW      = $clog2(GAP_CYC + 1) + 1;

    logic [HW-1:0] high_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_cnt <= HW'(GAP_CYC);
        end else if (!sel_n) begin
            high_cnt <= '0;
        end else if (high_cnt < HW'(GAP_CYC)) begin
            high_cnt <= high_cnt + HW'(1);
        end
    end

    a_r6_mosi_stable_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && $fell(sclk)) |-> $stable(mosi));

    a_r7_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> sclk);

    a_r8_gap_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_n) |-> (high_cnt >= HW'(GAP_CYC)));

    a_r9_done_after_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n) |=> done);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_busy_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |-> busy);

    a_r11_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !sel_n));
endmodule

bind chain_frame_tx cf_checks #(.DIV(DIV)) u_checks (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .sel_n (sel_n),
    .sclk  (sclk),
    .mosi  (mosi)
);

// File: tb/sim_chain_frame_tx.sv
module sim_chain_frame_tx;
    localparam int W   = 16;
    localparam int N   = 2;
    localparam int FW  = 4;
    localparam int DIV = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   lead_word = '0;
    logic [W*N-1:0] chain_words = '0;
    logic [FW-1:0]  fill_bits = '0;
    logic           busy, done, sel_n, sclk, mosi;

    int tests = 0;
    int fails = 0;

    bit exp_q[$];
    int fill_q[$];
    int frames_sent = 0;
    int frames_seen = 0;

    always #2.5 clk = ~clk;

    chain_frame_tx #(.WORD_W(W), .CHAIN_LEN(N), .FILL_W(FW), .DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .lead_word(lead_word),
        .chain_words(chain_words), .fill_bits(fill_bits), .busy(busy),
        .done(done), .sel_n(sel_n), .sclk(sclk), .mosi(mosi)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: pushes the expected frame and raises start once idle.
    task automatic send(input logic [W-1:0] l, input logic [W*N-1:0] c, input int f);
        @(negedge clk);
        while (busy) @(negedge clk);
        for (int i = W - 1; i >= 0; i--) exp_q.push_back(l[i]);
        for (int i = 0; i < f; i++) exp_q.push_back(1'b0);
        for (int k = N - 1; k >= 0; k--)
            for (int b = W - 1; b >= 0; b--) exp_q.push_back(c[k*W + b]);
        fill_q.push_back(f);
        frames_sent++;
        lead_word   = l;
        chain_words = c;
        fill_bits   = FW'(f);
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R11 busy after start", int'(busy), 1);
    endtask

    // Monitor: slave view of the bus, sampled between clock edges.
    logic prev_sclk = 1'b1;
    logic prev_sel  = 1'b1;
    int   bits_seen = 0;
    int   cur_fill  = 0;
    int   done_ph   = 0;
    int   high_cnt  = 1000;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done_ph == 1) begin
                chk(done == 1'b1, "R9 done pulse", int'(done), 1);
                done_ph = 2;
            end else if (done_ph == 2) begin
                chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
                done_ph = 0;
            end
            if (prev_sel && !sel_n) begin
                chk(high_cnt >= 4 * DIV, "R8 select gap", high_cnt, 4 * DIV);
                chk(fill_q.size() > 0, "R10 no unexpected frame", fill_q.size(), 1);
                if (fill_q.size() > 0) cur_fill = fill_q.pop_front();
                bits_seen = 0;
                frames_seen++;
            end
            if (!sel_n && prev_sclk && !sclk) begin
                string tag;
                if (bits_seen < W) tag = "R2 lead word bit";
                else if (bits_seen < W + cur_fill) tag = "R3 filler bit";
                else tag = "R4 chain word bit";
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 extra bit", bits_seen, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    chk(mosi == e, tag, int'(mosi), int'(e));
                end
                bits_seen++;
            end
            if (!prev_sel && sel_n) begin
                chk(bits_seen == W * (N + 1) + cur_fill, "R5 frame length",
                    bits_seen, W * (N + 1) + cur_fill);
                chk(sclk == 1'b1, "R7 sclk high at select rise", int'(sclk), 1);
                chk(done == 1'b0, "R9 done not early", int'(done), 0);
                done_ph  = 1;
                high_cnt = 0;
            end
            if (sel_n) high_cnt++;
            prev_sel  = sel_n;
            prev_sclk = sclk;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sel_n == 1'b1, "R1 sel_n reset", int'(sel_n), 1);
        chk(sclk == 1'b1, "R1 sclk reset", int'(sclk), 1);
        chk(mosi == 1'b0, "R1 mosi reset", int'(mosi), 0);
        chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);
        chk(done == 1'b0, "R1 done reset", int'(done), 0);

        // Minimum frame, no filler
        send(16'hA5C3, {16'hBEEF, 16'h1234}, 0);
        // Back-to-back: start lands as the gap closes
        send(16'h8001, {16'h0F0F, 16'hF00D}, 5);
        send(16'hFFFF, {16'hFFFF, 16'h0000}, 15);
        // R10: a request during a frame is ignored
        send(16'h3C5A, {16'h0001, 16'h8000}, 3);
        repeat (30) @(negedge clk);
        lead_word   = 16'h0000;
        chain_words = '0;
        fill_bits   = 4'd7;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        send(16'h0000, {16'h7FFE, 16'h5555}, 1);

        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all expected bits seen", exp_q.size(), 0);
        chk(frames_seen == frames_sent, "R10 frame count", frames_seen, frames_sent);
        chk(sel_n == 1'b1 && sclk == 1'b1, "R7 idle bus", int'(sclk), 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule